// File: doc/BRIEF.md
# Synchronous Burst Static RAM

A clocked static RAM model with a small internal array and a control port sampled entirely on the rising clock edge. A cycle begins when one of two address strobes is taken: a processor-side strobe, which only ever starts reads, or a controller-side strobe, which starts a read or a write depending on the write controls presented with it. Once a selected cycle is open, an advance input steps a two-bit burst counter. Each step either fetches the next word of a four-word aligned block or writes the current data into it.

The shared data bus is split into a data-in bus, a registered data-out bus and a drive-enable flag for the pad. Read data is loaded into the output register on the edge that accepts the read, so it is visible one clock-to-output delay later. The output enable then decides whether the pad is driven. After any write the pad floats until a later strobe or advance cycle performs a read. Three chip-enable inputs qualify every strobe: two are active low and one is active high.

Top module: `burst_sram`

## Requirements
- R1: The device is selected only when `ce_n`=0, `ce2_n`=0 and `ce3`=1 on the edge that takes a strobe. A strobe taken while deselected closes the open cycle, leaves `dout_en`=0 after that edge, and makes later advance pulses have no effect until a selected strobe arrives.
- R2: `cpu_as_n`=0 with `ce_n`=0 starts a read at `addr` whatever the write controls are, and it takes priority over `ctl_as_n`. When `ce_n`=1 the processor strobe is ignored, and `dout`/`dout_en` keep their previous values.
- R3: `ctl_as_n`=0 always starts a cycle. It is a write when at least one lane is enabled (see R4) and a read otherwise.
- R4: The data word has four 8-bit lanes, and lane n is bits 8n+7..8n. `gw_n`=0 enables all lanes. Otherwise, with `bwe_n`=0, lane n is enabled when `bw_n[n]`=0. Only the enabled lanes of the addressed word change.
- R5: `adv_n`=0 with no strobe, inside an open selected cycle, steps the burst counter. The word used is `addr[ADDR_W-1:2]` followed by `(addr[1:0]+count) mod 4`, so the order is linear and wraps inside the aligned block. The step writes when lanes are enabled and reads otherwise.
- R6: After a write edge `dout_en` is 0, and it stays 0 until a later strobe or advance cycle performs a read.
- R7: A read puts the addressed word on `dout` after the accepting edge. `dout_en` equals the read state ANDed with `oe_n`=0, so `oe_n`=1 floats the pad at once without losing the data. After reset `dout_en`=0.
- R8: An edge with no strobe taken and `adv_n`=1 leaves `dout`, the burst address and the array unchanged.
- R9: Reads started on consecutive edges, by either strobe, each return the word at their own address on the following sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address sampled with a strobe |
| cpu_as_n | input | 1 | Processor-side address strobe, active low |
| ctl_as_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2_n | input | 1 | Second chip enable, active low |
| ce3 | input | 1 | Third chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| din | input | DATA_W | Write data from the pad |
| dout | output | DATA_W | Registered read data toward the pad |
| dout_en | output | 1 | Pad drive enable |

## Verification
The bench builds the block with `ADDR_W`=4, which gives a sixteen-word array of four aligned burst blocks, and keeps the 32-bit, four-lane word. With an array that small, the bench can write every word, sweep every word back, and run bursts that wrap in more than one block. Lane masks such as alternating lanes and a single high lane stay visible in the readback. Reads and writes are mixed with deselects by each enable, with processor strobes ignored through `ce_n`, and with `oe_n` toggled in the middle of a read.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cpu_as_n,
  input  logic              ctl_as_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              ce_n,
  input  logic              ce2_n,
  input  logic              ce3,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic               open_q, rd_q;
  logic [DATA_W-1:0]  dout_q;

  wire cpu_go = !cpu_as_n && !ce_n;
  wire ctl_go = !ctl_as_n;
  wire start  = cpu_go || ctl_go;
  wire sel    = !ce_n && !ce2_n && ce3;

  wire [LANES-1:0] lane_we = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : {LANES{1'b0}});
  wire wr_req = |lane_we;
  wire st_wr  = ctl_go && !cpu_go && wr_req;
  wire take   = start && sel;
  wire step   = !start && !adv_n && open_q;

  wire [BURST_W-1:0] cnt_nx = cnt_q + 1'b1;
  wire [BURST_W-1:0] low_nx = base_q[BURST_W-1:0] + cnt_nx;
  wire [ADDR_W-1:0]  cur_a  = start ? addr : {base_q[ADDR_W-1:BURST_W], low_nx};

  wire go_wr = (take && st_wr) || (step && wr_req);
  wire go_rd = (take && !st_wr) || (step && !wr_req);

  always_ff @(posedge clk) begin
    if (go_wr) begin
      for (int i = 0; i < LANES; i++)
        if (lane_we[i]) mem[cur_a][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      open_q <= 1'b0;
      rd_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      if (start) begin
        base_q <= addr;
        cnt_q  <= '0;
        open_q <= sel;
        rd_q   <= go_rd;
      end else if (step) begin
        cnt_q  <= cnt_nx;
        rd_q   <= !wr_req;
      end
      if (go_rd) dout_q <= mem[cur_a];
    end
  end

  assign dout    = dout_q;
  assign dout_en = rd_q && !oe_n;

  assert_float_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr |=> !dout_en);
  assert_deselect_floats_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sel) |=> (!dout_en && !open_q));
  assert_cpu_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_as_n && ce_n && ctl_as_n && adv_n) |=> ($stable(dout_q) && $stable(rd_q)));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && adv_n) |=> ($stable(dout_q) && $stable(base_q) && $stable(cnt_q)));
  assert_burst_in_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(base_q));
endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cpu_as_n = 1, ctl_as_n = 1, adv_n = 1, gw_n = 1, bwe_n = 1;
  logic [3:0] bw_n = 4'hF;
  logic ce_n = 0, ce2_n = 0, ce3 = 1, oe_n = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  always #2 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANES(4), .BURST_W(2)) u_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_as_n(cpu_as_n), .ctl_as_n(ctl_as_n),
    .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .ce_n(ce_n), .ce2_n(ce2_n),
    .ce3(ce3), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en));

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [DW-1:0] ref_mem [16];
  bit ref_open = 0, ref_rd = 0;
  int ref_base = 0, ref_cnt = 0;
  logic [DW-1:0] ref_dout = '0;

  task automatic chk(input string req, input bit ok, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ref_write(input int a, input logic [3:0] lanes, input logic [DW-1:0] d);
    for (int n = 0; n < 4; n++)
      if (lanes[n]) ref_mem[a][8*n +: 8] = d[8*n +: 8];
  endtask

  task automatic cyc(input string req, input bit p_cpu, input bit p_ctl, input bit p_adv,
                     input bit p_gw, input bit p_bwe, input logic [3:0] p_bw,
                     input bit p_ce, input bit p_ce2, input bit p_ce3, input bit p_oe,
                     input int a, input logic [DW-1:0] d);
    bit cpu, ctl, sel, isw;
    logic [3:0] lanes;
    int ea;
    @(negedge clk);
    cpu_as_n = p_cpu; ctl_as_n = p_ctl; adv_n = p_adv; gw_n = p_gw; bwe_n = p_bwe;
    bw_n = p_bw; ce_n = p_ce; ce2_n = p_ce2; ce3 = p_ce3; oe_n = p_oe;
    addr = a[AW-1:0]; din = d;
    cpu = !p_cpu && !p_ce;
    ctl = !p_ctl;
    sel = !p_ce && !p_ce2 && p_ce3;
    lanes = !p_gw ? 4'hF : (!p_bwe ? ~p_bw : 4'h0);
    if (cpu || ctl) begin
      ref_base = a; ref_cnt = 0; ref_open = sel;
      if (!sel) ref_rd = 0;
      else begin
        isw = ctl && !cpu && (lanes != 0);
        if (isw) begin ref_write(a, lanes, d); ref_rd = 0; end
        else begin ref_dout = ref_mem[a]; ref_rd = 1; end
      end
    end else if (!p_adv && ref_open) begin
      ref_cnt = (ref_cnt + 1) % 4;
      ea = (ref_base & ~3) | ((ref_base + ref_cnt) & 3);
      if (lanes != 0) begin ref_write(ea, lanes, d); ref_rd = 0; end
      else begin ref_dout = ref_mem[ea]; ref_rd = 1; end
    end
    @(posedge clk);
    #1;
    chk(req, dout_en == (ref_rd && !p_oe), {31'b0, dout_en}, {31'b0, ref_rd && !p_oe});
    if (ref_rd) chk(req, dout == ref_dout, dout, ref_dout);
  endtask

  task automatic rd_cpu(input string req, input int a);
    cyc(req, 0, 1, 1, 1, 1, 4'hF, 0, 0, 1, 0, a, '0);
  endtask
  task automatic rd_ctl(input string req, input int a);
    cyc(req, 1, 0, 1, 1, 1, 4'hF, 0, 0, 1, 0, a, '0);
  endtask
  task automatic wr_ctl(input string req, input int a, input bit g, input logic [3:0] bw, input logic [DW-1:0] d);
    cyc(req, 1, 0, 1, g, 0, bw, 0, 0, 1, 0, a, d);
  endtask
  task automatic adv_rd(input string req, input bit oe);
    cyc(req, 1, 1, 0, 1, 1, 4'hF, 0, 0, 1, oe, 0, '0);
  endtask
  task automatic adv_wr(input string req, input logic [3:0] bw, input logic [DW-1:0] d);
    cyc(req, 1, 1, 0, 1, 0, bw, 0, 0, 1, 0, 0, d);
  endtask
  task automatic idle(input string req, input bit oe);
    cyc(req, 1, 1, 1, 1, 1, 4'hF, 0, 0, 1, oe, 9, 32'hDEADBEEF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset", dout_en == 0, {31'b0, dout_en}, '0);
    rst_n = 1;
    // R3 R4: full-word back-to-back writes over the whole array
    for (int i = 0; i < 16; i++) wr_ctl("R3 gw write", i, 0, 4'hF, 32'h1000_0000 + i * 32'h0101_0101);
    idle("R6 float after write", 0);
    // R9 R2: back-to-back reads, both strobes
    for (int i = 0; i < 16; i++) rd_cpu("R9 cpu reads", i);
    rd_ctl("R3 ctl read", 5);
    rd_cpu("R9 mixed", 12);
    rd_ctl("R9 mixed", 3);
    // R5 burst read with wrap from 6
    rd_cpu("R5 burst start", 6);
    for (int k = 0; k < 5; k++) adv_rd("R5 burst wrap", 0);
    // R4 lane writes
    wr_ctl("R4 lanes 0,2", 9, 1, 4'b1010, 32'hAABBCCDD);
    wr_ctl("R4 lane 3", 10, 1, 4'b0111, 32'h77665544);
    wr_ctl("R4 no lanes is read", 11, 1, 4'hF, 32'h0);
    rd_cpu("R4 readback", 9);
    rd_cpu("R4 readback", 10);
    // R6 float persists, then advance read drives
    wr_ctl("R6 write", 13, 0, 4'hF, 32'hCAFE_F00D);
    idle("R6 idle float", 0);
    idle("R6 idle float", 0);
    adv_rd("R6 adv reads", 0);
    // R2 ignored processor strobe
    rd_cpu("R2 base", 4);
    cyc("R2 ignored", 0, 1, 1, 1, 1, 4'hF, 1, 0, 1, 0, 8, '0);
    adv_rd("R2 still open", 0);
    // R1 deselects
    cyc("R1 ce3 low", 0, 1, 1, 1, 1, 4'hF, 0, 0, 0, 0, 2, '0);
    adv_rd("R1 adv ignored", 0);
    rd_cpu("R1 reselect", 2);
    cyc("R1 ce2 high", 1, 0, 1, 1, 1, 4'hF, 0, 1, 1, 0, 7, '0);
    cyc("R1 ce high ctl", 1, 0, 1, 0, 1, 4'hF, 1, 0, 1, 0, 7, 32'h0BAD_0BAD);
    rd_cpu("R1 no write", 7);
    // R7 output enable
    rd_ctl("R7 read", 14);
    idle("R7 oe high", 1);
    idle("R7 oe low again", 0);
    // R8 hold
    idle("R8 hold", 0);
    rd_cpu("R8 array intact", 9);
    // R5 burst write with wrap from 15
    wr_ctl("R5 bw start", 15, 0, 4'hF, 32'h5555_0000);
    adv_wr("R5 bw step", 4'h0, 32'h5555_0001);
    adv_wr("R5 bw step", 4'hE, 32'h5555_0002);
    adv_wr("R5 bw step", 4'h0, 32'h5555_0003);
    adv_rd("R5 wrap read", 0);
    for (int i = 0; i < 16; i++) rd_ctl("R9 final sweep", i);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule